// File: doc/BRIEF.md
# Packet byte counter and acknowledge decision unit

This unit follows the data bytes of one I2C/SMBus packet against a programmed size. A byte-level shifter reports each completed byte with a strobe. The unit keeps a remaining-byte count and uses it, together with the selected acknowledge policy, to decide whether the byte now on the wire is ACKed or NACKed. When the last counted byte completes, it raises an end-of-packet pulse and a sticky flag. It also produces a per-byte interrupt request, filtered according to the node's role and a next-is-data flag. It produces an effective NACK signal for the host, with an option to treat every NACK as an ACK.

The size register counts data bytes only, never address bytes. It is copied into the counter only while the bus is idle. When end-of-packet is placed after the PEC byte, the count covers one extra byte. A size of zero describes a Quick Command, which has no data phase. SCL/SDA signalling, the shifter itself and the CRC arithmetic are outside this unit.

Top module: `pkt_ack_ctrl`

## Requirements
- R1: After reset, `remaining` equals PSZ_RESET (default 1), and `eop_flag`, `eop_pulse`, `next_is_data` and `irq_byte` are 0.
- R2: Each clock edge with `bus_idle`=1 loads `remaining` with `psz_cfg`, plus one when `eop_mode`=2'b10. `remaining` is one bit wider than `psz_cfg`, so the largest size plus the PEC byte does not wrap. While `bus_idle`=0, changes on `psz_cfg` have no effect on `remaining`.
- R3: A data byte is a `byte_done` pulse while `next_is_data`=1 and `bus_idle`=0. Each data byte lowers `remaining` by one, holding at 0. A `byte_done` while `next_is_data`=0 leaves `remaining` unchanged.
- R4: `ack_nak` is 1 for NACK and 0 for ACK. With `ack_mode`=2'b01 it is always 0. With `ack_mode`=2'b00 it follows `sw_nak`.
- R5: With `ack_mode`=2'b10, `ack_nak` is 1 exactly when `next_is_data`=1 and `remaining`=1. Otherwise it is 0.
- R6: With `ack_mode`=2'b11 and `next_is_data`=1 and `remaining`=1, `ack_nak` is 1 for a host. For a client it equals the inverse of `crc_zero`. In every other case under this mode it is 0.
- R7: With `eop_mode` 2'b01 or 2'b10, `eop_pulse` is high for exactly one cycle, in the cycle after the data byte that takes `remaining` from 1 to 0. `eop_flag` sets in that same cycle and stays set until `eop_clr`. With `eop_mode` 2'b00 or 2'b11, neither output is raised.
- R8: With a size of 0 (Quick Command), data bytes leave `remaining` at 0 and produce no end-of-packet.
- R9: `nd_set` sets `next_is_data`. In client mode (`is_host`=0), `next_is_data` clears on `xfer_tx_start`, and it clears on a data byte received (`byte_rx`=1) while `remaining`=1. A clear wins over a simultaneous set. In host mode these two events leave the flag unchanged.
- R10: `irq_byte` is a one-cycle pulse in the cycle after `byte_done`. A host raises it for every byte. A client with `next_is_data`=1 raises it only when `byte_is_addr`=0. A client with `next_is_data`=0 raises it for every byte.
- R11: `peer_nak_eff` equals `peer_nak`, except that it is forced to 0 while `is_host`=1 and `nak_ignore`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| is_host | input | 1 | 1 = host role, 0 = client role |
| bus_idle | input | 1 | Bus idle; the packet size is loaded while high |
| psz_cfg | input | CNT_W | Programmed packet size in data bytes |
| ack_mode | input | 2 | Acknowledge policy select |
| eop_mode | input | 2 | End-of-packet placement select |
| sw_nak | input | 1 | Software acknowledge bit for ack_mode 00 (1 = NACK) |
| crc_zero | input | 1 | CRC residue is zero |
| nak_ignore | input | 1 | Host treats received NACK as ACK |
| peer_nak | input | 1 | Acknowledge bit received from the far end is NACK |
| nd_set | input | 1 | Sets next_is_data |
| xfer_tx_start | input | 1 | Client transmit begins |
| byte_done | input | 1 | Byte completed strobe from the shifter |
| byte_is_addr | input | 1 | Completed byte was an address byte |
| byte_rx | input | 1 | Completed byte was received by this node |
| eop_clr | input | 1 | Clears eop_flag |
| ack_nak | output | 1 | Acknowledge decision for the current byte (1 = NACK) |
| remaining | output | CNT_W+1 | Remaining byte count |
| eop_pulse | output | 1 | End-of-packet, one cycle |
| eop_flag | output | 1 | End-of-packet, sticky |
| next_is_data | output | 1 | Next byte is a data byte |
| irq_byte | output | 1 | Per-byte interrupt request pulse |
| peer_nak_eff | output | 1 | Received NACK after the ignore option |

## Verification
The bench builds the unit with CNT_W=4, PEC_EN=1 and PSZ_RESET=1. The narrow count lets the full-scale size of 15 plus the PEC byte reach the counter's extra top bit (value 16) within a few cycles. At this width the saturation at zero and the Quick Command size also sit a few bytes from a reload. A vector table covers every acknowledge policy at and away from the final byte, for both roles and both CRC outcomes. Directed tests follow for each end-of-packet mode, the reload window, the role-dependent flag clears and the interrupt filter.

// File: rtl/pkt_ack_pkg.sv
package pkt_ack_pkg;

   typedef enum logic [1:0] {
      ACK_SOFT  = 2'b00,
      ACK_ALL   = 2'b01,
      ACK_LAST  = 2'b10,
      ACK_CHECK = 2'b11
   } ack_pol_e;

   typedef enum logic [1:0] {
      EOP_NONE  = 2'b00,
      EOP_DATA  = 2'b01,
      EOP_PEC   = 2'b10,
      EOP_RSVD  = 2'b11
   } eop_pol_e;

   function automatic logic eop_enabled(input logic [1:0] m);
      return (m == EOP_DATA) || (m == EOP_PEC);
   endfunction

endpackage

// File: rtl/pkt_cnt.sv
module pkt_cnt
   import pkt_ack_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PSZ_RESET = 1,
   parameter bit PEC_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bus_idle,
   input  logic [CNT_W-1:0] psz_cfg,
   input  logic [1:0]       eop_mode,
   input  logic             data_done,
   input  logic             eop_clr,
   output logic [CNT_W:0]   cnt,
   output logic             last,
   output logic             eop_pulse,
   output logic             eop_flag
);
   localparam int CW = CNT_W + 1;
   localparam logic [CW-1:0] ONE  = {{CNT_W{1'b0}}, 1'b1};
   localparam logic [CW-1:0] ZERO = '0;

   logic [CW-1:0] load_val;
   logic          eop_hit;

   generate
      if (PEC_EN) begin : g_pec
         assign load_val = {1'b0, psz_cfg} + {{CNT_W{1'b0}}, (eop_mode == EOP_PEC)};
      end else begin : g_nopec
         assign load_val = {1'b0, psz_cfg};
      end
   endgenerate

   assign last    = (cnt == ONE);
   assign eop_hit = data_done && last && eop_enabled(eop_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= CW'(PSZ_RESET);
      end else if (bus_idle) begin
         cnt <= load_val;
      end else if (data_done && (cnt != ZERO)) begin
         cnt <= cnt - ONE;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         eop_pulse <= 1'b0;
         eop_flag  <= 1'b0;
      end else begin
         eop_pulse <= eop_hit;
         if (eop_hit)      eop_flag <= 1'b1;
         else if (eop_clr) eop_flag <= 1'b0;
      end
   end

   AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_idle && !data_done) |=> $stable(cnt)); // R2
   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_idle && data_done && cnt != ZERO) |=> (cnt == $past(cnt) - ONE)); // R3
   AST_EOP_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      eop_pulse |-> (cnt == ZERO)); // R7
   AST_EOP_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      eop_pulse |-> eop_flag); // R7
   AST_EOP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      eop_pulse |=> !eop_pulse); // R7

endmodule

// File: rtl/pkt_ack_sel.sv
module pkt_ack_sel
   import pkt_ack_pkg::*;
(
   input  logic [1:0] ack_mode,
   input  logic       is_host,
   input  logic       nd,
   input  logic       last,
   input  logic       sw_nak,
   input  logic       crc_zero,
   output logic       ack_nak
);
   always_comb begin
      case (ack_pol_e'(ack_mode))
         ACK_SOFT:  ack_nak = sw_nak;
         ACK_ALL:   ack_nak = 1'b0;
         ACK_LAST:  ack_nak = nd && last;
         ACK_CHECK: ack_nak = nd && last && (is_host || !crc_zero);
         default:   ack_nak = 1'b0;
      endcase
   end
endmodule

// File: rtl/pkt_nd_irq.sv
module pkt_nd_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic is_host,
   input  logic nd_set,
   input  logic xfer_tx_start,
   input  logic byte_done,
   input  logic byte_is_addr,
   input  logic byte_rx,
   input  logic last,
   output logic nd,
   output logic irq_byte
);
   logic nd_clr;
   logic irq_hit;

   assign nd_clr  = !is_host && (xfer_tx_start || (byte_done && nd && byte_rx && last));
   assign irq_hit = byte_done && (is_host || !nd || !byte_is_addr);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nd       <= 1'b0;
         irq_byte <= 1'b0;
      end else begin
         irq_byte <= irq_hit;
         if (nd_clr)      nd <= 1'b0;
         else if (nd_set) nd <= 1'b1;
      end
   end

   AST_ND_TX_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (!is_host && xfer_tx_start) |=> !nd); // R9
   AST_ND_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (nd_set && is_host) |=> nd); // R9
   AST_IRQ_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_byte |-> $past(byte_done)); // R10
   AST_IRQ_ADDR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_done && !is_host && nd && byte_is_addr) |=> !irq_byte); // R10

endmodule

// File: rtl/pkt_ack_ctrl.sv
module pkt_ack_ctrl
   import pkt_ack_pkg::*;
#(
   parameter int CNT_W     = 16,
   parameter int PSZ_RESET = 1,
   parameter bit PEC_EN    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             is_host,
   input  logic             bus_idle,
   input  logic [CNT_W-1:0] psz_cfg,
   input  logic [1:0]       ack_mode,
   input  logic [1:0]       eop_mode,
   input  logic             sw_nak,
   input  logic             crc_zero,
   input  logic             nak_ignore,
   input  logic             peer_nak,
   input  logic             nd_set,
   input  logic             xfer_tx_start,
   input  logic             byte_done,
   input  logic             byte_is_addr,
   input  logic             byte_rx,
   input  logic             eop_clr,
   output logic             ack_nak,
   output logic [CNT_W:0]   remaining,
   output logic             eop_pulse,
   output logic             eop_flag,
   output logic             next_is_data,
   output logic             irq_byte,
   output logic             peer_nak_eff
);
   generate
      if (CNT_W < 2 || CNT_W > 31) begin : g_bad_width
         $error("pkt_ack_ctrl: CNT_W must lie in 2..31");
      end
      if (PSZ_RESET < 0 || PSZ_RESET >= (1 << CNT_W)) begin : g_bad_reset
         $error("pkt_ack_ctrl: PSZ_RESET must fit in CNT_W bits");
      end
   endgenerate

   logic last;
   logic data_done;

   assign data_done    = byte_done && next_is_data && !bus_idle;
   assign peer_nak_eff = peer_nak && !(is_host && nak_ignore);

   pkt_cnt #(
      .CNT_W     (CNT_W),
      .PSZ_RESET (PSZ_RESET),
      .PEC_EN    (PEC_EN)
   ) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_idle  (bus_idle),
      .psz_cfg   (psz_cfg),
      .eop_mode  (eop_mode),
      .data_done (data_done),
      .eop_clr   (eop_clr),
      .cnt       (remaining),
      .last      (last),
      .eop_pulse (eop_pulse),
      .eop_flag  (eop_flag)
   );

   pkt_ack_sel u_sel (
      .ack_mode (ack_mode),
      .is_host  (is_host),
      .nd       (next_is_data),
      .last     (last),
      .sw_nak   (sw_nak),
      .crc_zero (crc_zero),
      .ack_nak  (ack_nak)
   );

   pkt_nd_irq u_nd (
      .clk           (clk),
      .rst_n         (rst_n),
      .is_host       (is_host),
      .nd_set        (nd_set),
      .xfer_tx_start (xfer_tx_start),
      .byte_done     (byte_done),
      .byte_is_addr  (byte_is_addr),
      .byte_rx       (byte_rx),
      .last          (last),
      .nd            (next_is_data),
      .irq_byte      (irq_byte)
   );

   AST_EXT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mode == ACK_ALL) |-> !ack_nak); // R4
   AST_NAK_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_mode != ACK_SOFT && !next_is_data) |-> !ack_nak); // R5
   AST_NAK_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
      (is_host && nak_ignore) |-> !peer_nak_eff); // R11

endmodule

// File: tb/pkt_ack_ctrl_tb.sv
module pkt_ack_ctrl_tb;
   localparam int CLK_PERIOD = 10;
   localparam int CW = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          is_host = 1'b1, bus_idle = 1'b0;
   logic [CW-1:0] psz_cfg = '0;
   logic [1:0]    ack_mode = 2'b00, eop_mode = 2'b00;
   logic          sw_nak = 1'b0, crc_zero = 1'b0, nak_ignore = 1'b0, peer_nak = 1'b0;
   logic          nd_set = 1'b0, xfer_tx_start = 1'b0, byte_done = 1'b0;
   logic          byte_is_addr = 1'b0, byte_rx = 1'b0, eop_clr = 1'b0;
   logic          ack_nak, eop_pulse, eop_flag, next_is_data, irq_byte, peer_nak_eff;
   logic [CW:0]   remaining;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   pkt_ack_ctrl #(.CNT_W(CW), .PSZ_RESET(1), .PEC_EN(1'b1)) u_dut (
      .clk(clk), .rst_n(rst_n), .is_host(is_host), .bus_idle(bus_idle),
      .psz_cfg(psz_cfg), .ack_mode(ack_mode), .eop_mode(eop_mode),
      .sw_nak(sw_nak), .crc_zero(crc_zero), .nak_ignore(nak_ignore),
      .peer_nak(peer_nak), .nd_set(nd_set), .xfer_tx_start(xfer_tx_start),
      .byte_done(byte_done), .byte_is_addr(byte_is_addr), .byte_rx(byte_rx),
      .eop_clr(eop_clr), .ack_nak(ack_nak), .remaining(remaining),
      .eop_pulse(eop_pulse), .eop_flag(eop_flag), .next_is_data(next_is_data),
      .irq_byte(irq_byte), .peer_nak_eff(peer_nak_eff)
   );

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 20000) begin
         checks++; fails++;
         $display("FAIL R1 watchdog actual=%0d expected<%0d", cyc, 20000);
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic load(input int p, input logic [1:0] e);
      psz_cfg = CW'(p); eop_mode = e; bus_idle = 1'b1;
      tick();
      bus_idle = 1'b0;
   endtask

   task automatic send_byte(input logic a, input logic r);
      byte_done = 1'b1; byte_is_addr = a; byte_rx = r;
      tick();
      byte_done = 1'b0; byte_is_addr = 1'b0; byte_rx = 1'b0;
   endtask

   task automatic set_nd(input logic v);
      if (v) begin
         nd_set = 1'b1; tick(); nd_set = 1'b0;
      end else begin
         is_host = 1'b0; xfer_tx_start = 1'b1; tick(); xfer_tx_start = 1'b0;
      end
   endtask

   // {host, ack_mode[1:0], nd, psz[3:0], sw_nak, crc_zero, expected ack_nak}
   localparam logic [10:0] VEC [11] = '{
      {1'b0, 2'b01, 1'b1, 4'd1, 1'b1, 1'b0, 1'b0},
      {1'b1, 2'b00, 1'b1, 4'd3, 1'b1, 1'b0, 1'b1},
      {1'b1, 2'b00, 1'b1, 4'd3, 1'b0, 1'b0, 1'b0},
      {1'b1, 2'b10, 1'b1, 4'd1, 1'b0, 1'b0, 1'b1},
      {1'b1, 2'b10, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
      {1'b1, 2'b10, 1'b0, 4'd1, 1'b0, 1'b0, 1'b0},
      {1'b1, 2'b11, 1'b1, 4'd1, 1'b0, 1'b1, 1'b1},
      {1'b1, 2'b11, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0},
      {1'b0, 2'b11, 1'b1, 4'd1, 1'b0, 1'b1, 1'b0},
      {1'b0, 2'b11, 1'b1, 4'd1, 1'b0, 1'b0, 1'b1},
      {1'b0, 2'b11, 1'b1, 4'd2, 1'b0, 1'b0, 1'b0}
   };

   initial begin
      tick(); tick();
      rst_n = 1'b1;
      tick();
      // R1 reset state
      chk("R1 remaining", int'(remaining), 1);
      chk("R1 eop_flag", int'(eop_flag), 0);
      chk("R1 eop_pulse", int'(eop_pulse), 0);
      chk("R1 next_is_data", int'(next_is_data), 0);
      chk("R1 irq_byte", int'(irq_byte), 0);

      // Acknowledge policy table (R4 R5 R6)
      for (int i = 0; i < 11; i++) begin
         logic [10:0] v;
         string tag;
         v = VEC[i];
         load(int'(v[6:3]), 2'b00);
         set_nd(v[7]);
         is_host = v[10]; ack_mode = v[9:8]; sw_nak = v[2]; crc_zero = v[1];
         tick();
         tag = (v[9:8] == 2'b10) ? "R5" : (v[9:8] == 2'b11) ? "R6" : "R4";
         chk($sformatf("%s vec%0d ack_nak", tag, i), int'(ack_nak), int'(v[0]));
      end
      ack_mode = 2'b01; sw_nak = 1'b0; crc_zero = 1'b0;

      // Counting and end-of-packet after data (R3 R7)
      is_host = 1'b1; set_nd(1'b1);
      load(3, 2'b01);
      chk("R2 load 3", int'(remaining), 3);
      send_byte(1'b0, 1'b0);
      chk("R3 dec to 2", int'(remaining), 2);
      chk("R7 no early eop", int'(eop_pulse), 0);
      send_byte(1'b0, 1'b0);
      chk("R3 dec to 1", int'(remaining), 1);
      send_byte(1'b0, 1'b0);
      chk("R3 dec to 0", int'(remaining), 0);
      chk("R7 eop_pulse", int'(eop_pulse), 1);
      chk("R7 eop_flag set", int'(eop_flag), 1);
      tick();
      chk("R7 pulse one cycle", int'(eop_pulse), 0);
      chk("R7 flag sticky", int'(eop_flag), 1);
      send_byte(1'b0, 1'b0);
      chk("R3 hold at 0", int'(remaining), 0);
      chk("R7 no eop at 0", int'(eop_pulse), 0);
      eop_clr = 1'b1; tick(); eop_clr = 1'b0;
      chk("R7 flag cleared", int'(eop_flag), 0);

      // No decrement for non-data bytes (R3)
      load(5, 2'b01);
      set_nd(1'b0); is_host = 1'b1;
      send_byte(1'b1, 1'b0);
      chk("R3 addr byte no dec", int'(remaining), 5);

      // End-of-packet after PEC (R2 R7)
      set_nd(1'b1);
      load(2, 2'b10);
      chk("R2 pec load", int'(remaining), 3);
      send_byte(1'b0, 1'b0);
      send_byte(1'b0, 1'b0);
      chk("R7 pec no eop after data", int'(eop_pulse), 0);
      chk("R7 pec one left", int'(remaining), 1);
      send_byte(1'b0, 1'b0);
      chk("R7 pec eop", int'(eop_pulse), 1);
      eop_clr = 1'b1; tick(); eop_clr = 1'b0;

      // Disabled and reserved end-of-packet modes (R7)
      load(1, 2'b00);
      send_byte(1'b0, 1'b0);
      chk("R7 mode00 no eop", int'(eop_pulse), 0);
      chk("R2 mode00 no extra", int'(remaining), 0);
      load(1, 2'b11);
      chk("R2 mode11 no extra", int'(remaining), 1);
      send_byte(1'b0, 1'b0);
      chk("R7 mode11 no eop", int'(eop_pulse), 0);
      chk("R7 mode11 no flag", int'(eop_flag), 0);

      // Full-scale size plus PEC, and ignored writes while busy (R2)
      load(15, 2'b10);
      chk("R2 wide load", int'(remaining), 16);
      psz_cfg = 4'd3;
      tick(); tick();
      chk("R2 busy write ignored", int'(remaining), 16);

      // Quick Command (R8)
      load(0, 2'b01);
      send_byte(1'b0, 1'b0);
      chk("R8 quick remaining", int'(remaining), 0);
      chk("R8 quick no eop", int'(eop_pulse), 0);
      chk("R8 quick no flag", int'(eop_flag), 0);

      // next_is_data handling (R9)
      is_host = 1'b0; set_nd(1'b1);
      load(1, 2'b00);
      send_byte(1'b0, 1'b1);
      chk("R9 client rx end clears", int'(next_is_data), 0);
      is_host = 1'b1; set_nd(1'b1);
      load(1, 2'b00);
      send_byte(1'b0, 1'b1);
      chk("R9 host rx end keeps", int'(next_is_data), 1);
      xfer_tx_start = 1'b1; tick(); xfer_tx_start = 1'b0;
      chk("R9 host tx start keeps", int'(next_is_data), 1);
      is_host = 1'b0; nd_set = 1'b1; xfer_tx_start = 1'b1;
      tick();
      nd_set = 1'b0; xfer_tx_start = 1'b0;
      chk("R9 clear beats set", int'(next_is_data), 0);

      // Interrupt filter (R10)
      is_host = 1'b1;
      send_byte(1'b1, 1'b0);
      chk("R10 host addr irq", int'(irq_byte), 1);
      tick();
      chk("R10 irq one cycle", int'(irq_byte), 0);
      is_host = 1'b0; set_nd(1'b1); is_host = 1'b0;
      load(4, 2'b00);
      send_byte(1'b1, 1'b0);
      chk("R10 client nd addr masked", int'(irq_byte), 0);
      send_byte(1'b0, 1'b0);
      chk("R10 client nd data irq", int'(irq_byte), 1);
      set_nd(1'b0);
      send_byte(1'b1, 1'b0);
      chk("R10 client addr irq", int'(irq_byte), 1);

      // NACK ignore (R11)
      peer_nak = 1'b1; is_host = 1'b1; nak_ignore = 1'b1; #1;
      chk("R11 host ignore", int'(peer_nak_eff), 0);
      nak_ignore = 1'b0; #1;
      chk("R11 host normal", int'(peer_nak_eff), 1);
      is_host = 1'b0; nak_ignore = 1'b1; #1;
      chk("R11 client unaffected", int'(peer_nak_eff), 1);
      peer_nak = 1'b0; #1;
      chk("R11 no nak", int'(peer_nak_eff), 0);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule